// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Diagnostic and Pattern Modes

This block is a full-duplex asynchronous serial port. It sends and receives 8-bit characters, each framed by a low start bit and one high stop bit. Every bit lasts sixteen oversampling ticks. The ticks come from one of two sources: an internal divider running on the system clock, or the rising edges of an external serial clock. The external clock is synchronised first and may run at up to half the system clock rate. Characters enter and leave through valid/ready byte streams.

The receiver checks each start bit at its mid-point and throws away glitches that turn out to be false starts. It recognises a line break, which is a frame that stays low through its stop bit. It then waits for the line to go idle before it hunts for the next start bit, so it resynchronises without outside help.

Three modes support diagnostics and signal generation. Loopback feeds the transmitter into the receiver and holds the pin idle. Echo copies the received line onto the transmit pin. Pattern mode sends the last accepted byte again and again with no gap between frames, which makes the transmit line usable as a PWM source.

Top module: `sercom_core`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1, `rx_valid` is 0 and `rx_break` is 0.
- R2: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` then stays 0 until the frame ends. On the pin the frame is one 0 start bit, then 8 data bits with the least significant bit first, then one 1 stop bit, each bit 16 ticks long.
- R3: With `clk_sel`=0 a tick occurs once every `baud_div`+1 system clocks. With `clk_sel`=1 a tick occurs on each rising edge of `ext_sclk`, after a two-flop synchroniser. With `ext_sclk` stopped, no bit time advances.
- R4: The receiver takes a low line as a start candidate and samples each data bit once every 16 ticks. When the stop bit is sampled high, it puts the byte on `rx_data` and raises `rx_valid`. `rx_valid` stays 1 until a clock edge where `rx_ready` is 1.
- R5: If the line is high at the eighth tick of the start bit, `rx_false_start` pulses for one cycle, the receiver returns to hunting, and no character is reported.
- R6: A frame that is low in every data bit and in the stop bit sets `rx_break` and reports no character. `rx_break` stays 1 while the line stays low and clears once the line is sampled high. The next frame is then received normally.
- R7: With `loop_en`=1 the transmitter output drives the receiver, `txd` is held at 1, and the `rxd` pin is ignored.
- R8: With `echo_en`=1 (and `loop_en`=0), `txd` equals `rxd` delayed by two system clocks, and `tx_ready` is held at 0.
- R9: With `pat_en`=1 the last accepted byte is framed and sent back-to-back, one frame every 160 ticks with no idle time. After `pat_en` is cleared, the current frame completes and the transmitter goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sclk | input | 1 | External serial clock |
| clk_sel | input | 1 | Tick source: 0 internal divider, 1 external clock |
| baud_div | input | DIV_W | Internal divider; tick period is baud_div+1 clocks |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | rx_data holds an unread byte |
| rx_ready | input | 1 | Consumer takes rx_data |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| loop_en | input | 1 | Internal loopback mode |
| echo_en | input | 1 | Echo received line to txd |
| pat_en | input | 1 | Repeat last byte continuously |
| rx_break | output | 1 | Break condition on the receive line |
| rx_false_start | output | 1 | One-cycle pulse on a rejected start bit |

## Verification
The bench keeps the default parameters: a 16-bit divider field, 8-bit characters and 16x oversampling. It drives `baud_div`=3, so one bit lasts 64 clocks and a whole frame 640. At that rate break frames, pattern streams and full back-to-back character sequences run within a few thousand cycles. The external clock is run at a quarter of the system rate, which gives the same bit time, so the same frame timing checks apply. Stopping that clock shows that the internal divider is really bypassed.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BRKWAIT
  } rx_state_e;

endpackage

// File: rtl/sercom_tick.sv
module sercom_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_sel,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             ext_sclk,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [2:0]       ext_q, ext_d;
  logic             int_tick;

  always_comb begin
    int_tick = (cnt_q == '0);
    cnt_d    = int_tick ? baud_div : cnt_q - 1'b1;
    ext_d    = {ext_q[1:0], ext_sclk};
    tick     = clk_sel ? (ext_q[1] & ~ext_q[2]) : int_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ext_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ext_q <= ext_d;
    end
  end

endmodule

// File: rtl/sercom_tx.sv
module sercom_tx
  import sercom_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pat_en,
  input  logic              block_in,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              line
);

  localparam int OVS_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [OVS_W-1:0] SUB_LAST = OVS_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  tx_state_e         st_q, st_d;
  logic [OVS_W-1:0]  sub_q, sub_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] pat_q, pat_d;

  always_comb begin
    st_d     = st_q;
    sub_d    = sub_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    pat_d    = pat_q;
    in_ready = (st_q == TX_IDLE) && !block_in;
    if (in_valid && in_ready) begin
      sh_d  = in_data;
      pat_d = in_data;
      st_d  = TX_START;
      sub_d = '0;
    end else if (tick && st_q != TX_IDLE) begin
      sub_d = sub_q + 1'b1;
      if (sub_q == SUB_LAST) begin
        case (st_q)
          TX_START: begin
            st_d  = TX_DATA;
            bit_d = '0;
          end
          TX_DATA: begin
            sh_d  = sh_q >> 1;
            bit_d = bit_q + 1'b1;
            if (bit_q == BIT_LAST) st_d = TX_STOP;
          end
          TX_STOP: begin
            if (pat_en) begin
              st_d = TX_START;
              sh_d = pat_q;
            end else begin
              st_d = TX_IDLE;
            end
          end
          default: st_d = TX_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (st_q)
      TX_START: line = 1'b0;
      TX_DATA:  line = sh_q[0];
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      sub_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      pat_q <= '0;
    end else begin
      st_q  <= st_d;
      sub_q <= sub_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      pat_q <= pat_d;
    end
  end

endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
  import sercom_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              brk,
  output logic              false_start
);

  localparam int OVS_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [OVS_W-1:0] SUB_LAST = OVS_W'(OVS - 1);
  localparam logic [OVS_W-1:0] SUB_MID  = OVS_W'(OVS / 2 - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  rx_state_e         st_q, st_d;
  logic [OVS_W-1:0]  sub_q, sub_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              vld_q, vld_d;
  logic              fs_q, fs_d;

  always_comb begin
    st_d  = st_q;
    sub_d = sub_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    dat_d = dat_q;
    vld_d = vld_q;
    fs_d  = 1'b0;
    if (vld_q && out_ready) vld_d = 1'b0;
    if (tick) begin
      case (st_q)
        RX_IDLE: begin
          if (!line) begin
            st_d  = RX_START;
            sub_d = '0;
          end
        end
        RX_START: begin
          sub_d = sub_q + 1'b1;
          if (sub_q == SUB_MID) begin
            if (line) begin
              st_d = RX_IDLE;
              fs_d = 1'b1;
            end else begin
              st_d  = RX_DATA;
              sub_d = '0;
              bit_d = '0;
            end
          end
        end
        RX_DATA: begin
          sub_d = sub_q + 1'b1;
          if (sub_q == SUB_LAST) begin
            sh_d  = {line, sh_q[DATA_W-1:1]};
            bit_d = bit_q + 1'b1;
            if (bit_q == BIT_LAST) st_d = RX_STOP;
          end
        end
        RX_STOP: begin
          sub_d = sub_q + 1'b1;
          if (sub_q == SUB_LAST) begin
            if (line) begin
              dat_d = sh_q;
              vld_d = 1'b1;
              st_d  = RX_IDLE;
            end else if (sh_q == '0) begin
              st_d = RX_BRKWAIT;
            end else begin
              st_d = RX_IDLE;
            end
          end
        end
        RX_BRKWAIT: begin
          if (line) st_d = RX_IDLE;
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  assign out_data    = dat_q;
  assign out_valid   = vld_q;
  assign brk         = (st_q == RX_BRKWAIT);
  assign false_start = fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      sub_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      dat_q <= '0;
      vld_q <= 1'b0;
      fs_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      sub_q <= sub_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      dat_q <= dat_d;
      vld_q <= vld_d;
      fs_q  <= fs_d;
    end
  end

endmodule

// File: rtl/sercom_core.sv
module sercom_core #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_sclk,
  input  logic              clk_sel,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              txd,
  input  logic              rxd,
  input  logic              loop_en,
  input  logic              echo_en,
  input  logic              pat_en,
  output logic              rx_break,
  output logic              rx_false_start
);

  logic [1:0] rst_q;
  logic       rst_n_s;
  logic [1:0] rxs_q;
  logic       tick;
  logic       tx_line;
  logic       rx_line;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rxs_q <= 2'b11;
    else          rxs_q <= {rxs_q[0], rxd};
  end

  sercom_tick #(.DIV_W(DIV_W)) tick_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clk_sel  (clk_sel),
    .baud_div (baud_div),
    .ext_sclk (ext_sclk),
    .tick     (tick)
  );

  sercom_tx #(.DATA_W(DATA_W), .OVS(OVS)) tx_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .tick     (tick),
    .pat_en   (pat_en),
    .block_in (echo_en),
    .in_data  (tx_data),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .line     (tx_line)
  );

  assign rx_line = loop_en ? tx_line : rxs_q[1];
  assign txd     = loop_en ? 1'b1 : (echo_en ? rxs_q[1] : tx_line);

  sercom_rx #(.DATA_W(DATA_W), .OVS(OVS)) rx_i (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .tick        (tick),
    .line        (rx_line),
    .out_data    (rx_data),
    .out_valid   (rx_valid),
    .out_ready   (rx_ready),
    .brk         (rx_break),
    .false_start (rx_false_start)
  );

endmodule

// File: rtl/sercom_chk.sv
module sercom_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_ready,
  input logic txd,
  input logic rxd,
  input logic loop_en,
  input logic echo_en,
  input logic rx_break,
  input logic rx_false_start
);

  logic [2:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 3'd7)  age_q <= age_q + 1'b1;
  end

  AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready); // R2

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> (loop_en || echo_en || !txd)); // R2

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid); // R4

  AST_FS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_false_start |=> !rx_false_start); // R5

  AST_BRK_NO_FS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |-> !rx_false_start); // R6

  AST_LOOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en && $past(loop_en) |-> txd); // R7

  AST_ECHO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_en && !loop_en && age_q >= 3'd4) |-> txd == $past(rxd, 2)); // R8

  AST_ECHO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    echo_en |-> !tx_ready); // R8

endmodule

bind sercom_core sercom_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .tx_valid       (tx_valid),
  .tx_ready       (tx_ready),
  .rx_valid       (rx_valid),
  .rx_ready       (rx_ready),
  .txd            (txd),
  .rxd            (rxd),
  .loop_en        (loop_en),
  .echo_en        (echo_en),
  .rx_break       (rx_break),
  .rx_false_start (rx_false_start)
);

// File: tb/sercom_core_tb_top.sv
module sercom_core_tb_top;

  localparam int DIV  = 3;
  localparam int BITC = (DIV + 1) * 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_sclk = 1'b0;
  logic        clk_sel = 1'b0;
  logic [15:0] baud_div = 16'(DIV);
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic        txd;
  logic        rxd = 1'b1;
  logic        loop_en = 1'b0;
  logic        echo_en = 1'b0;
  logic        pat_en = 1'b0;
  logic        rx_break;
  logic        rx_false_start;

  int          n_chk = 0;
  int          n_fail = 0;
  longint      cyc = 0;
  int          pops = 0;
  int          fs_seen = 0;
  int          loop_bad = 0;
  longint      last_pop = 0;
  longint      gap = 0;
  logic        ext_run = 1'b0;
  int          ext_cnt = 0;
  bit          done = 1'b0;
  logic [7:0]  exp_q[$];

  sercom_core dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ext_sclk       (ext_sclk),
    .clk_sel        (clk_sel),
    .baud_div       (baud_div),
    .tx_data        (tx_data),
    .tx_valid       (tx_valid),
    .tx_ready       (tx_ready),
    .rx_data        (rx_data),
    .rx_valid       (rx_valid),
    .rx_ready       (rx_ready),
    .txd            (txd),
    .rxd            (rxd),
    .loop_en        (loop_en),
    .echo_en        (echo_en),
    .pat_en         (pat_en),
    .rx_break       (rx_break),
    .rx_false_start (rx_false_start)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_false_start) fs_seen++;
      if (loop_en && txd !== 1'b1) loop_bad++;
      if (rx_valid && rx_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected character", longint'(rx_data), 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R4 received byte", longint'(rx_data), longint'(e));
        end
        gap = cyc - last_pop;
        last_pop = cyc;
        pops++;
      end
    end
  end

  // external serial clock: one rising edge every 4 system clocks
  always @(negedge clk) begin
    if (ext_run) begin
      ext_cnt++;
      if (ext_cnt % 2 == 0) ext_sclk = ~ext_sclk;
    end
  end

  task automatic send(input logic [7:0] b);
    while (!tx_ready) @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic drive_frame(input logic [7:0] b, input logic stopv);
    rxd = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BITC) @(negedge clk);
    end
    rxd = stopv;
    repeat (BITC) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic drain(input string req);
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    int p0;
    int fs0;
    logic [7:0] pb;
    logic [9:0] fr;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 reset state
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    chk(rx_break == 1'b0, "R1 rx_break", rx_break, 0);

    // R7 loopback with the rxd pin forced low (ignored)
    loop_en = 1'b1;
    rxd = 1'b0;
    @(negedge clk);
    exp_q.push_back(8'hA5); exp_q.push_back(8'h00);
    exp_q.push_back(8'hFF); exp_q.push_back(8'h3C);
    send(8'hA5); send(8'h00); send(8'hFF); send(8'h3C);
    drain("R7 loopback characters received");
    chk(loop_bad == 0, "R7 txd held high in loopback", loop_bad, 0);
    chk(rx_break == 1'b0, "R7 rxd pin ignored", rx_break, 0);
    rxd = 1'b1;
    repeat (20) @(negedge clk);
    loop_en = 1'b0;
    repeat (20) @(negedge clk);

    // R2 framing on the pin
    pb = 8'h96;
    fr = {1'b1, pb, 1'b0};
    send(pb);
    chk(tx_ready == 1'b0, "R2 tx_ready low during frame", tx_ready, 0);
    repeat (BITC / 2 - 1) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      chk(txd == fr[i], "R2 tx frame bit", txd, fr[i]);
      repeat (BITC) @(negedge clk);
    end
    chk(tx_ready == 1'b1, "R2 tx_ready after frame", tx_ready, 1);

    // R4 reception from the pin
    exp_q.push_back(8'h5A);
    drive_frame(8'h5A, 1'b1);
    exp_q.push_back(8'h81);
    drive_frame(8'h81, 1'b1);
    drain("R4 pin characters received");

    // R4 rx_valid held until rx_ready
    rx_ready = 1'b0;
    exp_q.push_back(8'h77);
    drive_frame(8'h77, 1'b1);
    repeat (100) @(negedge clk);
    chk(rx_valid == 1'b1, "R4 rx_valid held", rx_valid, 1);
    chk(rx_data == 8'h77, "R4 rx_data held", rx_data, 8'h77);
    rx_ready = 1'b1;
    drain("R4 held character taken");

    // R5 false start
    fs0 = fs_seen;
    p0 = pops;
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITC) @(negedge clk);
    chk(fs_seen == fs0 + 1, "R5 false start pulse", fs_seen - fs0, 1);
    chk(pops == p0, "R5 no character", pops - p0, 0);
    exp_q.push_back(8'h42);
    drive_frame(8'h42, 1'b1);
    drain("R5 recovery character");

    // R6 break and resynchronisation
    p0 = pops;
    rxd = 1'b0;
    repeat (12 * BITC) @(negedge clk);
    chk(rx_break == 1'b1, "R6 break flagged", rx_break, 1);
    chk(pops == p0, "R6 no character on break", pops - p0, 0);
    rxd = 1'b1;
    repeat (100) @(negedge clk);
    chk(rx_break == 1'b0, "R6 break cleared", rx_break, 0);
    exp_q.push_back(8'h69);
    drive_frame(8'h69, 1'b1);
    drain("R6 resync character");

    // R8 echo
    echo_en = 1'b1;
    tx_data = 8'hE7;
    tx_valid = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1'b0, "R8 tx blocked in echo", tx_ready, 0);
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    chk(txd == 1'b0, "R8 echo low", txd, 0);
    rxd = 1'b1;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R8 echo high", txd, 1);
    tx_valid = 1'b0;
    repeat (3 * BITC) @(negedge clk);
    echo_en = 1'b0;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R8 no byte taken in echo", tx_ready, 1);
    repeat (BITC) @(negedge clk);
    chk(txd == 1'b1, "R8 line idle after echo", txd, 1);

    // R9 pattern mode through loopback
    loop_en = 1'b1;
    pat_en = 1'b1;
    @(negedge clk);
    p0 = pops;
    for (int i = 0; i < 4; i++) exp_q.push_back(8'hC3);
    send(8'hC3);
    while (pops < p0 + 4) @(negedge clk);
    chk(tx_ready == 1'b0, "R9 busy while repeating", tx_ready, 0);
    pat_en = 1'b0;
    chk(gap == 10 * BITC, "R9 frame spacing", gap, 10 * BITC);
    repeat (20 * BITC) @(negedge clk);
    chk(pops == p0 + 4, "R9 stops after clear", pops - p0, 4);
    chk(tx_ready == 1'b1, "R9 idle after clear", tx_ready, 1);

    // R3 external clock source
    clk_sel = 1'b1;
    @(negedge clk);
    p0 = pops;
    exp_q.push_back(8'h3A);
    send(8'h3A);
    repeat (2000) @(negedge clk);
    chk(pops == p0, "R3 no progress without ext clock", pops - p0, 0);
    chk(tx_ready == 1'b0, "R3 frame pending", tx_ready, 0);
    ext_run = 1'b1;
    drain("R3 character on ext clock");
    exp_q.push_back(8'h1F);
    send(8'h1F);
    drain("R3 second ext character");
    ext_run = 1'b0;
    clk_sel = 1'b0;
    loop_en = 1'b0;

    repeat (10) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule